// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output Mode

This block is a first-in first-out buffer between two independent clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. The two clocks may be unrelated or may be the same net. Storage is a dual-port array, written on the write clock and read through a registered port on the read clock, so it maps onto block RAM. The read and write pointers cross between the domains as Gray codes through two-stage synchronizers. As a result the status flags are conservative: a flag that shows the buffer as full or empty may release late, but it never releases early.

A master reset latches one of two output modes from `ft_sel`. In standard mode a word stays in the array until a read request fetches it. The port-A flag then means full and the port-B flag means empty. In fall-through mode the oldest word is moved into the output register without a request, and `empty_or` reports that valid data is waiting. `full_ir` then reports that space is free. A partial reset flushes both pointers and keeps the latched mode. The almost-full and almost-empty thresholds come in as inputs: almost-full is produced in the write domain and almost-empty in the read domain.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave the buffer in the order they were accepted. A write is accepted only on a rising `wclk` edge with `wen` high and space free. A read is accepted only on a rising `rclk` edge with `rden` high and data available.
- R2: Standard mode (`ft_sel`=0 at master reset): a stored word does not reach `rdata` until a read is accepted. It appears on `rdata` right after the `rclk` edge that accepts the read.
- R3: Fall-through mode (`ft_sel`=1 at master reset): with shared clocks, the word written into an empty buffer appears on `rdata` with `empty_or`=1 after the 4th `rclk` edge following the write edge. The word and the flag hold until a read is accepted. `empty_or` drops at the edge that reads the last word.
- R4: Flag encoding. In standard mode `full_ir`=1 means full and `empty_or`=1 means empty. In fall-through mode `full_ir`=1 means space is available and `empty_or`=1 means valid data is on `rdata`.
- R5: Capacity is DEPTH = 2^AW words in the array. In standard mode the buffer shows full after exactly DEPTH writes. In fall-through mode it holds DEPTH words plus one word in the output register.
- R6: A write while full and a read while empty (standard) or while `empty_or`=0 (fall-through) are ignored and leave the pointers unchanged.
- R7: `afull`=1, in the `wclk` domain, when the write-side word count is at least DEPTH − `af_off`.
- R8: `aempty`=1, in the `rclk` domain, when the read-side word count is at most `ae_off`. In fall-through mode the read-side count includes the word held in the output register.
- R9: Master reset (`mrst`=1, held for at least two edges of both clocks) clears both pointers and latches the mode from `ft_sel`. The flags then read: not full, empty, `afull`=0, `aempty`=1.
- R10: Partial reset (`prst`=1) empties the buffer in the same way but keeps the latched mode. `ft_sel` is ignored during a partial reset.
- R11: In standard mode with shared clocks, `empty_or` falls after the 3rd `rclk` edge following a write into an empty buffer. `full_ir` falls after the 3rd `wclk` edge following a read from a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous and active high, seen in both domains |
| prst | input | 1 | Partial reset that flushes the pointers and keeps the mode |
| ft_sel | input | 1 | Mode latched at master reset: 0 standard, 1 fall-through |
| wen | input | 1 | Write request |
| wdata | input | DW | Write data |
| af_off | input | AW | Almost-full offset from the full boundary |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| afull | output | 1 | Almost full |
| rden | input | 1 | Read request |
| rdata | output | DW | Read data, registered |
| ae_off | input | AW | Almost-empty offset from the empty boundary |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| aempty | output | 1 | Almost empty |

## Verification
The bench drives both clocks from one 100 MHz source, so every latency becomes a fixed count of edges. A word written at edge k releases the empty flag after edge k+3 and reaches the fall-through output after edge k+4. A read at edge k releases the full flag after edge k+3. Standard-mode read data is due right after the accepting edge, and fall-through data is compared before the accepting edge. Inputs change and outputs are sampled on falling edges. The latency checks look one edge before and exactly at the due edge. The almost flags are compared only after at least four idle edges, so both synchronizers have settled.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wctl.sv
module dcf_wctl #(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          clr,
  input  logic          wen,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_off,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          winc,
  output logic          full,
  output logic          afull
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(1) << AW;

  logic [AW:0] wbin, wbin_nx, wgray_nx, rbin_s, lvl_nx, af_lim, full_pat;

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign winc     = wen & ~full;
  assign wbin_nx  = wbin + (AW+1)'(winc);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign lvl_nx   = wbin_nx - rbin_s;
  assign af_lim   = DEPTH_V - {1'b0, af_off};
  assign full_pat = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk) begin
    if (clr) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == full_pat);
      afull <= (lvl_nx >= af_lim);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (clr) (full && wen) |=> $stable(wbin)); // R6
  AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (clr) $onehot0(wgray ^ $past(wgray))); // R1
  AST_FULL_IS_AFULL: assert property (@(posedge wclk) disable iff (clr) full |-> afull); // R7
endmodule

// File: rtl/dcf_rctl.sv
module dcf_rctl #(
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          clr,
  input  logic          ft_en,
  input  logic          rden,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          ren,
  output logic          empty,
  output logic          ovalid,
  output logic          aempty
);
  logic [AW:0]   rbin, rbin_nx, rgray_nx, wbin_s;
  logic [AW+1:0] lvl_nx;
  logic          rinc, ovalid_nx;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  // standard: fetch on request; fall-through: refill output register when free or being read
  assign rinc      = ft_en ? (~empty & (~ovalid | rden)) : (rden & ~empty);
  assign ren       = rinc;
  assign ovalid_nx = ft_en & (rinc | (ovalid & ~rden));
  assign rbin_nx   = rbin + (AW+1)'(rinc);
  assign rgray_nx  = (rbin_nx >> 1) ^ rbin_nx;
  assign lvl_nx    = {1'b0, wbin_s - rbin_nx} + (AW+2)'(ovalid_nx);
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge rclk) begin
    if (clr) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      ovalid <= 1'b0;
      aempty <= 1'b1;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rgray_nx;
      empty  <= (rgray_nx == wgray_s);
      ovalid <= ovalid_nx;
      aempty <= (lvl_nx <= {2'b0, ae_off});
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (clr) empty |=> $stable(rbin)); // R6
  AST_OR_HOLDS: assert property (@(posedge rclk) disable iff (clr) (ovalid && !rden) |=> ovalid); // R3
  AST_STD_EMPTY_IS_AEMPTY: assert property (@(posedge rclk) disable iff (clr) (!ft_en && empty) |-> aempty); // R8
  AST_RGRAY_ONE_STEP: assert property (@(posedge rclk) disable iff (clr) $onehot0(rgray ^ $past(rgray))); // R1
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          ft_sel,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] af_off,
  output logic          full_ir,
  output logic          afull,
  input  logic          rden,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] ae_off,
  output logic          empty_or,
  output logic          aempty
);
  fifo_mode_e    mode_w, mode_r;
  logic          wclr, rclr;
  logic [AW:0]   wgray, rgray, wgray_r, rgray_w;
  logic [AW-1:0] waddr, raddr;
  logic          winc, ren, full, empty, ovalid;

  assign wclr = mrst | prst;
  assign rclr = mrst | prst;

  // mode is configuration: only a master reset loads it
  always_ff @(posedge wclk) begin
    if (mrst) mode_w <= ft_sel ? MODE_FWFT : MODE_STD;
  end

  always_ff @(posedge rclk) begin
    if (mrst) mode_r <= ft_sel ? MODE_FWFT : MODE_STD;
  end

  dcf_wctl #(.AW(AW)) u_wctl (
    .wclk(wclk), .clr(wclr), .wen(wen), .rgray_s(rgray_w), .af_off(af_off),
    .waddr(waddr), .wgray(wgray), .winc(winc), .full(full), .afull(afull)
  );

  dcf_rctl #(.AW(AW)) u_rctl (
    .rclk(rclk), .clr(rclr), .ft_en(mode_r == MODE_FWFT), .rden(rden),
    .wgray_s(wgray_r), .ae_off(ae_off), .raddr(raddr), .rgray(rgray),
    .ren(ren), .empty(empty), .ovalid(ovalid), .aempty(aempty)
  );

  dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .clr(wclr), .d(rgray), .q(rgray_w)
  );

  dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .clr(rclr), .d(wgray), .q(wgray_r)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(winc), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .re(ren), .raddr(raddr), .rdata(rdata)
  );

  assign full_ir  = (mode_w == MODE_FWFT) ? ~full : full;
  assign empty_or = (mode_r == MODE_FWFT) ? ovalid : empty;

  AST_FT_DATA_STABLE: assert property (@(posedge rclk) disable iff (rclr) (mode_r == MODE_FWFT && empty_or && !rden) |=> $stable(rdata)); // R3
  AST_STD_NO_OVALID: assert property (@(posedge rclk) disable iff (rclr) (mode_r == MODE_STD) |-> !ovalid); // R2
endmodule

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AF = 3;
  localparam int AE = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic mrst = 1'b1, prst = 1'b0, ft_sel = 1'b0, wen = 1'b0, rden = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] af_off = AW'(AF), ae_off = AW'(AE);
  logic full_ir, afull, empty_or, aempty;
  logic [DW-1:0] rdata;

  dual_clock_fifo #(.DW(DW), .AW(AW)) i_dual_clock_fifo (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .ft_sel(ft_sel),
    .wen(wen), .wdata(wdata), .af_off(af_off), .full_ir(full_ir), .afull(afull),
    .rden(rden), .rdata(rdata), .ae_off(ae_off), .empty_or(empty_or), .aempty(aempty)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  bit cur_ft = 1'b0;
  logic [DW-1:0] q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_afull(input int n);
    return n >= DEPTH - AF;
  endfunction

  function automatic bit exp_aempty(input int n);
    return n <= AE;
  endfunction

  function automatic bit can_wr();
    return cur_ft ? full_ir : !full_ir;
  endfunction

  function automatic bit can_rd();
    return cur_ft ? empty_or : !empty_or;
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_check(input string req);
    if (q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s actual=%0h expected=<nothing>", req, rdata);
    end else begin
      check(req, 32'(rdata), 32'(q.pop_front()));
    end
  endtask

  task automatic do_reset(input bit ft, input bit partial);
    wen = 1'b0; rden = 1'b0; ft_sel = ft;
    if (partial) prst = 1'b1; else mrst = 1'b1;
    tick(3);
    mrst = 1'b0; prst = 1'b0;
    if (!partial) cur_ft = ft;
    q.delete();
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    bit ok;
    ok = can_wr();
    wen = 1'b1; wdata = d;
    tick();
    wen = 1'b0;
    if (ok) q.push_back(d);
  endtask

  task automatic rd1(input string req);
    bit ok;
    ok = can_rd();
    if (ok && cur_ft) pop_check(req);
    rden = 1'b1;
    tick();
    rden = 1'b0;
    if (ok && !cur_ft) pop_check(req);
  endtask

  task automatic run_random(input int cycles, input int wp, input int rp);
    for (int c = 0; c < cycles; c++) begin
      bit w, r, wa, ra;
      logic [DW-1:0] d;
      w  = ($urandom % 4) < 32'(wp);
      r  = ($urandom % 4) < 32'(rp);
      d  = DW'($urandom);
      wa = w && can_wr();
      ra = r && can_rd();
      if (ra && cur_ft) pop_check("R1 random order");
      wen = w; rden = r; wdata = d;
      tick();
      if (wa) q.push_back(d);
      if (ra && !cur_ft) pop_check("R1 random order");
    end
    wen = 1'b0; rden = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // ---- standard mode after master reset
    do_reset(1'b0, 1'b0);
    check("R9 reset full_ir", 32'(full_ir), 0);
    check("R9 reset empty_or", 32'(empty_or), 1);
    check("R9 reset afull", 32'(afull), 0);
    check("R9 reset aempty", 32'(aempty), 1);

    wr1(16'hA5A5);
    tick(2);
    check("R11 empty still set at k+2", 32'(empty_or), 1);
    tick();
    check("R11 empty released at k+3", 32'(empty_or), 0);
    check("R2 word not on rdata before read", 32'(rdata != 16'hA5A5), 1);
    rd1("R2 read data after accepting edge");
    check("R4 std empty flag after last read", 32'(empty_or), 1);

    rden = 1'b1; tick(2); rden = 1'b0;
    wr1(16'h5A5A);
    tick(4);
    rd1("R6 read while empty ignored");

    for (int n = 0; n <= DEPTH; n++) begin
      tick(4);
      check("R7 afull level", 32'(afull), 32'(exp_afull(n)));
      check("R8 aempty level", 32'(aempty), 32'(exp_aempty(n)));
      check("R5 full after DEPTH writes", 32'(full_ir), 32'(n == DEPTH));
      if (n < DEPTH) wr1(DW'(16'h0100 + n));
    end
    wr1(16'hDEAD);
    rd1("R1 first of full buffer");
    tick(2);
    check("R11 full still set at k+2", 32'(full_ir), 1);
    tick();
    check("R11 full released at k+3", 32'(full_ir), 0);
    for (int i = 1; i < DEPTH; i++) rd1("R1 drain order");
    tick(4);
    check("R6 write while full was dropped", 32'(empty_or), 1);

    run_random(600, 3, 2);
    run_random(600, 2, 3);
    run_random(80, 0, 4);
    tick(4);
    check("R1 std all words delivered", 32'(q.size()), 0);

    // ---- fall-through mode
    do_reset(1'b1, 1'b0);
    check("R4 ft input-ready after reset", 32'(full_ir), 1);
    check("R9 ft output-ready low after reset", 32'(empty_or), 0);
    wr1(16'hC0DE);
    tick(3);
    check("R3 output-ready low at k+3", 32'(empty_or), 0);
    tick();
    check("R3 output-ready high at k+4", 32'(empty_or), 1);
    check("R3 head word falls through", 32'(rdata), 32'h0000C0DE);
    tick(3);
    check("R3 head word held without read", 32'(rdata), 32'h0000C0DE);
    rd1("R3 read consumes head");
    check("R3 output-ready drops on last read", 32'(empty_or), 0);
    rden = 1'b1; tick(2); rden = 1'b0;
    wr1(16'h1234);
    tick(4);
    check("R6 read with output-ready low ignored", 32'(rdata), 32'h00001234);
    rd1("R3 consume");

    wr1(16'h0200);
    tick(5);
    for (int i = 1; i <= DEPTH; i++) wr1(DW'(16'h0200 + i));
    check("R5 ft holds DEPTH plus one", 32'(full_ir), 0);
    wr1(16'hBEEF);
    tick(4);
    for (int i = 0; i <= DEPTH; i++) rd1("R1 ft drain order");
    tick(5);
    check("R6 ft write while full dropped", 32'(empty_or), 0);
    check("R8 ft aempty when drained", 32'(aempty), 1);

    run_random(600, 3, 2);
    run_random(600, 2, 3);
    run_random(80, 0, 4);
    tick(5);
    check("R1 ft all words delivered", 32'(q.size()), 0);

    // ---- partial reset keeps fall-through mode
    for (int i = 0; i < 5; i++) wr1(DW'(16'h0300 + i));
    tick(5);
    do_reset(1'b0, 1'b1);
    check("R10 flushed, still input-ready", 32'(full_ir), 1);
    check("R10 flushed, output-ready low", 32'(empty_or), 0);
    wr1(16'h7777);
    tick(4);
    check("R10 mode kept: word falls through", 32'(empty_or), 1);
    check("R10 fall-through data", 32'(rdata), 32'h00007777);

    tick(2);
    finish_run();
  end
endmodule